// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed station-management master for Ethernet PHYs. It produces the management clock from the system clock and shifts complete management frames on a bidirectional data line, which is presented as three signals: output value, output enable and input. Both the original short framing (Clause 22) and the extended framing with a separate address cycle (Clause 45) are supported. A framing-select bit in a mode register decides how the same two-bit access code is interpreted.

Software loads the PHY address and the register or device number, loads the write-data register, and then writes the command register with the start bit and an access code. It polls the busy flag until it clears. For a read, the returned 16-bit value then sits in the read-data register. An extended-framing read is two commands: an address frame that carries the register number from the write-data register, then a read frame. An extended write is likewise an address frame followed by a write frame, with the write-data register reloaded with the value in between. The register port is a single-cycle port: a write takes effect at the clock edge, and the read value follows the address combinationally.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy is 0, MDC is low, the output enable is 0, and every register reads 0.
- R2: The mode register at offset 0x40 holds all 32 bits written to it and reads them back unchanged. Its bit 8 selects the framing: 0 is Clause 22 and 1 is Clause 45.
- R3: The address register at 0x44 keeps the PHY address in bits [12:8] and the register or device number in bits [4:0]. Every other bit reads 0. The write-data register at 0x48 keeps bits [15:0].
- R4: Writing the command register at 0x50 with bit 8 set and a legal code sets busy (bit 16 of the command register) at that clock edge. Busy then stays set for exactly (PRE_LEN+32) × CLK_DIV clock cycles and clears on the last falling edge of MDC.
- R5: A start request is ignored, and leaves busy, the frame in flight and the stored code untouched, if it arrives while busy is set or if it carries an illegal code. Codes 2 and 3 are illegal in Clause 22; code 3 is illegal in Clause 45.
- R6: A Clause 22 frame is sent MSB first as follows: PRE_LEN ones, start 01, opcode 10 for code 0 (read) or 01 for code 1 (write), a 5-bit PHY address, a 5-bit register number, turnaround 10 on writes, and 16 data bits taken from the write-data register.
- R7: A Clause 45 frame uses start 00 and opcode 00 for code 0 (address), 01 for code 1 (write) or 11 for code 2 (read). The 5-bit field after the PHY address carries the device number. Address and write frames carry the write-data register as their 16 data bits.
- R8: MDC is the system clock divided by CLK_DIV, with its low half first, and it stays low while idle. The data output changes only when MDC falls. Input data is sampled when MDC rises.
- R9: A read frame releases the output enable from the first turnaround bit through the last data bit. Address and write frames drive the line for the whole frame.
- R10: The read-data register at 0x4C takes the 16 bits sampled during the data field, MSB first, at the end of a read frame. Address and write frames leave it unchanged.
- R11: The command register reads back the last accepted code in bits [1:0] and busy in bit 16. Its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for bus_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The hardest case to reach is a start request, together with a rewrite of the address register, that arrives in the middle of a Clause 45 read frame. If the design mishandles it, the only evidence is a single wrong bit late in the frame or a changed stored code. The bench raises both writes part-way through the preamble of an extended read. Its per-cycle model then expects the original frame, timing and returned data to carry on unchanged, and it checks that the command readback still shows the earlier code. The illegal codes in each framing are also issued while the block is idle, and busy and the line are watched for several cycles after each one.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

   localparam logic [7:0] OFS_MODE  = 8'h40;
   localparam logic [7:0] OFS_ADDR  = 8'h44;
   localparam logic [7:0] OFS_WDATA = 8'h48;
   localparam logic [7:0] OFS_RDATA = 8'h4C;
   localparam logic [7:0] OFS_CMD   = 8'h50;

   localparam int CLAUSE_BIT = 8;
   localparam int START_BIT  = 8;
   localparam int BUSY_BIT   = 16;

   typedef enum logic [1:0] {
      OP_ADDR = 2'b00,
      OP_WR   = 2'b01,
      OP_RD22 = 2'b10,
      OP_RD45 = 2'b11
   } op_e;

   typedef struct packed {
      logic [1:0]  st;
      logic [1:0]  op;
      logic [4:0]  phy;
      logic [4:0]  reg_f;
      logic [1:0]  ta;
      logic [15:0] data;
   } frame_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int DIV = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise,
   output logic fall
);
   localparam int HALF = DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
      $error("mdio_clkgen: DIV must be even and at least 2");
   end

   logic tick;
   logic mdc_q;

   if (HALF == 1) begin : g_fast
      assign tick = run;
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        cnt_q <= '0;
         else if (!run)                     cnt_q <= '0;
         else if (cnt_q == CW'(HALF - 1))   cnt_q <= '0;
         else                               cnt_q <= cnt_q + 1'b1;
      end
      assign tick = run && (cnt_q == CW'(HALF - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mdc_q <= 1'b0;
      else if (!run)  mdc_q <= 1'b0;
      else if (tick)  mdc_q <= ~mdc_q;
   end

   assign mdc  = mdc_q;
   assign rise = tick && !mdc_q;
   assign fall = tick && mdc_q;

endmodule

// File: rtl/mdio_frame_fmt.sv
module mdio_frame_fmt
   import mdio_master_pkg::*;
(
   input  logic        c45,
   input  logic [1:0]  code,
   input  logic [4:0]  phy,
   input  logic [4:0]  regad,
   input  logic [15:0] wdata,
   output frame_t      word,
   output logic        is_read,
   output logic        legal
);
   always_comb begin
      word       = '0;
      word.st    = c45 ? 2'b00 : 2'b01;
      word.phy   = phy;
      word.reg_f = regad;
      word.ta    = 2'b10;
      word.data  = wdata;
      is_read    = 1'b0;
      legal      = 1'b1;
      if (c45) begin
         case (code)
            2'd0:    word.op = OP_ADDR;
            2'd1:    word.op = OP_WR;
            2'd2: begin
               word.op = OP_RD45;
               is_read = 1'b1;
            end
            default: legal = 1'b0;
         endcase
      end else begin
         case (code)
            2'd0: begin
               word.op = OP_RD22;
               is_read = 1'b1;
            end
            2'd1:    word.op = OP_WR;
            default: legal = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
   import mdio_master_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  frame_t      word,
   input  logic        is_read,
   input  logic        rise,
   input  logic        fall,
   input  logic        mdio_i,
   output logic        busy,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic        rd_load,
   output logic [15:0] rd_val
);
   localparam int TOTAL    = PRE_LEN + 32;
   localparam int IW       = $clog2(TOTAL);
   localparam int TA_POS   = PRE_LEN + 14;
   localparam int DATA_POS = PRE_LEN + 16;

   logic          busy_q;
   logic [IW-1:0] idx_q;
   logic [31:0]   sh_q;
   logic          rd_q;
   logic [15:0]   cap_q;
   logic          last;

   assign last = busy_q && fall && (idx_q == IW'(TOTAL - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         sh_q   <= '0;
         rd_q   <= 1'b0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         sh_q   <= word;
         rd_q   <= is_read;
      end else if (busy_q && fall) begin
         if (last) busy_q <= 1'b0;
         else      idx_q  <= idx_q + 1'b1;
         if (idx_q >= IW'(PRE_LEN)) sh_q <= {sh_q[30:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cap_q <= '0;
      else if (busy_q && rise && rd_q && idx_q >= IW'(DATA_POS))
         cap_q <= {cap_q[14:0], mdio_i};
   end

   assign busy    = busy_q;
   assign mdio_o  = (busy_q && idx_q >= IW'(PRE_LEN)) ? sh_q[31] : 1'b1;
   assign mdio_oe = busy_q && !(rd_q && idx_q >= IW'(TA_POS));
   assign rd_load = last && rd_q;
   assign rd_val  = cap_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_master_pkg::*;
#(
   parameter int CLK_DIV = 50,
   parameter int PRE_LEN = 32,
   parameter int ADDR_W  = 8,
   parameter int BUS_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   if (BUS_W < BUSY_BIT + 1) begin : g_bad_bus
      $error("mdio_master: BUS_W too narrow for the command register");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("mdio_master: ADDR_W must reach offset 0x50");
   end
   if (PRE_LEN < 1) begin : g_bad_pre
      $error("mdio_master: PRE_LEN must be positive");
   end

   logic [BUS_W-1:0] mode_q;
   logic [4:0]       phy_q;
   logic [4:0]       regad_q;
   logic [15:0]      wdat_q;
   logic [15:0]      rdat_q;
   logic [1:0]       code_q;

   logic   sel_mode, sel_addr, sel_wdat, sel_rdat, sel_cmd;
   frame_t fr_word;
   logic   fr_read, fr_legal;
   logic   busy, start;
   logic   tick_rise, tick_fall;
   logic   rd_load;
   logic [15:0] rd_val;

   assign sel_mode = bus_addr == ADDR_W'(OFS_MODE);
   assign sel_addr = bus_addr == ADDR_W'(OFS_ADDR);
   assign sel_wdat = bus_addr == ADDR_W'(OFS_WDATA);
   assign sel_rdat = bus_addr == ADDR_W'(OFS_RDATA);
   assign sel_cmd  = bus_addr == ADDR_W'(OFS_CMD);

   assign start = bus_we && sel_cmd && bus_wdata[START_BIT] && fr_legal && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         phy_q   <= '0;
         regad_q <= '0;
         wdat_q  <= '0;
         code_q  <= '0;
      end else if (bus_we) begin
         if (sel_mode) mode_q <= bus_wdata;
         if (sel_addr) begin
            phy_q   <= bus_wdata[12:8];
            regad_q <= bus_wdata[4:0];
         end
         if (sel_wdat) wdat_q <= bus_wdata[15:0];
         if (start)    code_q <= bus_wdata[1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdat_q <= '0;
      else if (rd_load) rdat_q <= rd_val;
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_mode) bus_rdata = mode_q;
      if (sel_addr) begin
         bus_rdata[12:8] = phy_q;
         bus_rdata[4:0]  = regad_q;
      end
      if (sel_wdat) bus_rdata[15:0] = wdat_q;
      if (sel_rdat) bus_rdata[15:0] = rdat_q;
      if (sel_cmd) begin
         bus_rdata[1:0]      = code_q;
         bus_rdata[BUSY_BIT] = busy;
      end
   end

   mdio_frame_fmt u_fmt (
      .c45     (mode_q[CLAUSE_BIT]),
      .code    (bus_wdata[1:0]),
      .phy     (phy_q),
      .regad   (regad_q),
      .wdata   (wdat_q),
      .word    (fr_word),
      .is_read (fr_read),
      .legal   (fr_legal)
   );

   mdio_clkgen #(.DIV(CLK_DIV)) u_clk (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .mdc  (mdc),
      .rise (tick_rise),
      .fall (tick_fall)
   );

   mdio_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .word    (fr_word),
      .is_read (fr_read),
      .rise    (tick_rise),
      .fall    (tick_fall),
      .mdio_i  (mdio_i),
      .busy    (busy),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe),
      .rd_load (rd_load),
      .rd_val  (rd_val)
   );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        busy,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe,
   input logic [15:0] rdat
);
   assert_start_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   assert_ends_mdc_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !mdc);

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   assert_out_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_o) |-> $fell(mdc));

   assert_oe_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_oe) |-> ($fell(mdc) || $rose(busy)));

   assert_rdat_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdat) |-> $fell(busy));
endmodule

bind mdio_master mdio_master_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe),
   .rdat    (rdat_q)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;
   localparam int TOT  = 64;
   localparam logic [7:0] A_MODE = 8'h40, A_ADDR = 8'h44, A_WD = 8'h48,
                          A_RD = 8'h4C, A_CMD = 8'h50;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = A_CMD;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   logic [15:0] exp_rd = 16'h0;

   always #5 clk = ~clk;

   mdio_master #(.CLK_DIV(DIV)) i_mdio_master (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         bad++; total++;
         $display("FAIL watchdog: act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = A_CMD;
   endtask

   task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a; #1;
      chk(req, bus_rdata, exp);
      bus_addr = A_CMD;
   endtask

   // Expected frame word, built from the requirement text of R6 and R7
   function automatic logic [31:0] frame_of(input bit c45, input logic [1:0] code,
                                            input logic [4:0] phy, input logic [4:0] rg,
                                            input logic [15:0] wd);
      logic [1:0] st, op;
      st = c45 ? 2'b00 : 2'b01;
      if (c45) op = (code == 2'd0) ? 2'b00 : (code == 2'd1) ? 2'b01 : 2'b11;
      else     op = (code == 2'd0) ? 2'b10 : 2'b01;
      return {st, op, phy, rg, 2'b10, wd};
   endfunction

   task automatic run_frame(input string req, input bit c45, input logic [1:0] code,
                            input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] wd, input logic [15:0] resp,
                            input bit inject);
      logic [31:0] w;
      bit is_rd;
      w     = frame_of(c45, code, phy, rg, wd);
      is_rd = c45 ? (code == 2'd2) : (code == 2'd0);
      wr(A_ADDR, {19'd0, phy, 3'd0, rg});
      wr(A_WD, {16'd0, wd});
      wr(A_CMD, 32'h100 | {30'd0, code});
      for (int e = 0; e <= TOT * DIV; e++) begin
         int b;
         bit eb, em, eoe, eo;
         bus_we = 1'b0; bus_addr = A_CMD;
         b   = e / DIV;
         eb  = e < TOT * DIV;
         em  = eb && ((e / HALF) % 2 == 1);
         eoe = eb && !(is_rd && b >= 46);
         eo  = (!eb || b < 32) ? 1'b1 : w[63 - b];
         mdio_i = (eb && is_rd && b >= 48) ? resp[63 - b] : 1'b1;
         #1;
         chk({req, " R4 busy"}, {31'd0, bus_rdata[16]}, {31'd0, eb});
         chk({req, " R8 mdc"}, {31'd0, mdc}, {31'd0, em});
         chk({req, " R9 oe"}, {31'd0, mdio_oe}, {31'd0, eoe});
         if (eoe) chk({req, " data bit"}, {31'd0, mdio_o}, {31'd0, eo});
         if (inject && e == 20) begin
            bus_we = 1'b1; bus_wdata = 32'h101;   // R5: start while busy
         end
         if (inject && e == 21) begin
            bus_we = 1'b1; bus_addr = A_ADDR; bus_wdata = 32'h0000_1F1F;
         end
         @(negedge clk);
      end
      bus_we = 1'b0; bus_addr = A_CMD;
      if (is_rd) exp_rd = resp;
      rd({req, " R10 read data"}, A_RD, {16'd0, exp_rd});
      rd({req, " R11 cmd readback"}, A_CMD, {30'd0, code});
   endtask

   task automatic try_illegal(input string req, input logic [1:0] code,
                              input logic [1:0] prev);
      wr(A_CMD, 32'h100 | {30'd0, code});
      for (int k = 0; k < 10; k++) begin
         #1;
         chk({req, " R5 busy"}, {31'd0, bus_rdata[16]}, 32'd0);
         chk({req, " R5 oe"}, {30'd0, mdc, mdio_oe}, 32'd0);
         @(negedge clk);
      end
      rd({req, " R5 code kept"}, A_CMD, {30'd0, prev});
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk("R1 busy", {31'd0, bus_rdata[16]}, 32'd0);
      chk("R1 line", {30'd0, mdc, mdio_oe}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      rd("R1 mode", A_MODE, 32'd0);
      rd("R1 addr", A_ADDR, 32'd0);
      rd("R1 wdata", A_WD, 32'd0);
      rd("R1 rdata", A_RD, 32'd0);
      rd("R1 cmd", A_CMD, 32'd0);

      wr(A_MODE, 32'hFFFF_FEFF);
      rd("R2 mode full", A_MODE, 32'hFFFF_FEFF);
      wr(A_ADDR, 32'hFFFF_FFFF);
      rd("R3 addr mask", A_ADDR, 32'h0000_1F1F);
      wr(A_WD, 32'hFFFF_ABCD);
      rd("R3 wdata mask", A_WD, 32'h0000_ABCD);

      wr(A_MODE, 32'hA5A5_A0A5);
      rd("R2 mode c22", A_MODE, 32'hA5A5_A0A5);
      run_frame("R6 c22 read", 1'b0, 2'd0, 5'h11, 5'h03, 16'h0000, 16'hBEEF, 1'b0);
      run_frame("R6 c22 write", 1'b0, 2'd1, 5'h05, 5'h1A, 16'h1234, 16'h0000, 1'b0);
      try_illegal("c22 code2", 2'd2, 2'd1);
      try_illegal("c22 code3", 2'd3, 2'd1);

      wr(A_MODE, 32'hA5A5_A1A5);
      rd("R2 mode c45", A_MODE, 32'hA5A5_A1A5);
      run_frame("R7 c45 addr", 1'b1, 2'd0, 5'h1E, 5'h07, 16'h8001, 16'h0000, 1'b0);
      run_frame("R7 c45 write", 1'b1, 2'd1, 5'h1E, 5'h07, 16'h55AA, 16'h0000, 1'b0);
      try_illegal("c45 code3", 2'd3, 2'd1);
      run_frame("R7 c45 addr2", 1'b1, 2'd0, 5'h02, 5'h01, 16'h0010, 16'h0000, 1'b0);
      run_frame("R5 R7 c45 read", 1'b1, 2'd2, 5'h02, 5'h01, 16'h0000, 16'h6C93, 1'b1);
      rd("R5 addr write while busy", A_ADDR, 32'h0000_1F1F);

      wr(A_MODE, 32'h0000_0000);
      run_frame("R6 c22 read2", 1'b0, 2'd0, 5'h00, 5'h1F, 16'h0000, 16'h0001, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule